// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a synchronous host port and an asynchronous dynamic memory with a shared row/column address bus. A host asks for one 4-bit read or write at an 18-bit address. The block first puts the upper half of the address on the 9-bit bus and drops the row strobe. It then puts the lower half on the bus and drops the column strobe. Every strobe dwell is a whole number of clocks set by a parameter.

Writes are early writes. The write strobe is low before the column strobe falls, and the output-enable strobe stays high for the whole cycle. Reads keep the write strobe high, drop both the column strobe and the output enable, and capture the data a set number of clocks after the column strobe falls.

A separate scheduler can ask for a refresh of one row. The block serves that request as a row-strobe-only cycle with the column strobe held high. A refresh request takes precedence over a host request waiting in the same idle cycle, but it never breaks into a cycle that has already started. Every cycle ends with a row precharge of at least a set number of clocks.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `mem_ras_n`, `mem_cas_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe`, `host_done` and `ref_ack` are 0.
- R2: When `mem_ras_n` falls, `mem_addr` carries `host_addr[17:9]` and has held that value for at least one clock. When `mem_cas_n` falls, `mem_addr` carries `host_addr[8:0]`.
- R3: In a write (`host_we`=1), `mem_we_n` is already 0 in the clock before `mem_cas_n` falls. `mem_oe_n` stays 1 for the whole cycle. `mem_dq_out` carries `host_wdata` with `mem_dq_oe`=1, so a later read of the same address returns that data.
- R4: In a read (`host_we`=0), `mem_we_n` stays 1 while `mem_cas_n` and `mem_oe_n` are 0. `mem_dq_in` is captured at the T_CAC-th rising edge after the edge that drops `mem_cas_n`.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. In the clock before `mem_dq_oe` rises, `mem_oe_n` is 1.
- R6: Before every falling edge of `mem_ras_n`, `mem_ras_n` has been 1 for at least T_RP clocks.
- R7: A refresh (`ref_req`=1) drops `mem_ras_n` with `ref_row` on `mem_addr` and keeps `mem_cas_n`, `mem_we_n` and `mem_oe_n` at 1. `ref_ack` is a one-clock pulse, seen T_RSU+T_RAH+T_RP+2 clocks after the request is raised from idle.
- R8: If `ref_req` and `host_req` are both high in an idle cycle, the refresh runs first. A `ref_req` raised during a host cycle does not change that cycle's timing, and it is served right after that cycle.
- R9: `host_done` is a one-clock pulse, seen T_RSU+T_RAH+T_CSU+T_CAC+T_RP+2 clocks after a request is raised from idle.
- R10: While `host_done` is 1 after a read, `host_rdata` holds the captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host request, held until `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address, row in the upper half |
| host_wdata | input | 4 | Write data |
| host_rdata | output | 4 | Read data |
| host_done | output | 1 | One-clock end-of-cycle pulse |
| ref_req | input | 1 | Refresh request, held until `ref_ack` |
| ref_row | input | 9 | Row to refresh |
| ref_ack | output | 1 | One-clock refresh-complete pulse |
| mem_addr | output | 9 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output-enable strobe, active low |
| mem_dq_out | output | 4 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 4 | Data returned by the memory |

## Verification
The two functions that can meet in one cycle are host access and refresh arbitration. The bench raises `ref_req` and `host_req` on the same idle clock edge. It requires `ref_ack` at the refresh latency, then `host_done` exactly one host latency after that, with correct read data. A second scenario raises `ref_req` three clocks into a host write. That write must finish at its unchanged latency, the refresh must follow immediately after it, and the memory model must see no column strobe during the refresh.

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
  parameter int AW    = 9,
  parameter int DW    = 4,
  parameter int T_RSU = 1,
  parameter int T_RAH = 2,
  parameter int T_CSU = 1,
  parameter int T_CAC = 3,
  parameter int T_RP  = 3,
  parameter int CW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [2*AW-1:0] host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_done,
  input  logic            ref_req,
  input  logic [AW-1:0]   ref_row,
  output logic            ref_ack,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ras_n,
  output logic            mem_cas_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);

  typedef enum logic [2:0] {IDLE, ROW_SETUP, RAS_LOW, COL_SETUP, CAS_LOW, ACCESS, PRECHARGE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          op_ref, op_we;
  logic [AW-1:0] row_q, col_q;
  logic [DW-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      op_ref     <= 1'b0;
      op_we      <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wd_q       <= '0;
      host_rdata <= '0;
      host_done  <= 1'b0;
      ref_ack    <= 1'b0;
    end else begin
      host_done <= 1'b0;
      ref_ack   <= 1'b0;
      if (st != IDLE && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          IDLE: begin
            if (ref_req) begin
              op_ref <= 1'b1;
              op_we  <= 1'b0;
              row_q  <= ref_row;
              st     <= ROW_SETUP;
              cnt    <= CW'(T_RSU - 1);
            end else if (host_req) begin
              op_ref <= 1'b0;
              op_we  <= host_we;
              row_q  <= host_addr[2*AW-1:AW];
              col_q  <= host_addr[AW-1:0];
              wd_q   <= host_wdata;
              st     <= ROW_SETUP;
              cnt    <= CW'(T_RSU - 1);
            end
          end
          ROW_SETUP: begin
            st  <= RAS_LOW;
            cnt <= CW'(T_RAH - 1);
          end
          RAS_LOW: begin
            if (op_ref) begin
              st  <= ACCESS;
              cnt <= '0;
            end else begin
              st  <= COL_SETUP;
              cnt <= CW'(T_CSU - 1);
            end
          end
          COL_SETUP: begin
            st  <= CAS_LOW;
            cnt <= CW'(T_CAC - 1);
          end
          CAS_LOW: begin
            if (!op_we) host_rdata <= mem_dq_in;
            st  <= ACCESS;
            cnt <= '0;
          end
          ACCESS: begin
            st  <= PRECHARGE;
            cnt <= CW'(T_RP - 1);
          end
          PRECHARGE: begin
            st <= IDLE;
            if (op_ref) ref_ack <= 1'b1;
            else        host_done <= 1'b1;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  wire in_ras  = st inside {RAS_LOW, COL_SETUP, CAS_LOW, ACCESS};
  wire in_col  = st inside {COL_SETUP, CAS_LOW, ACCESS};
  wire in_cas  = !op_ref && st inside {CAS_LOW, ACCESS};

  assign mem_addr   = in_col ? col_q : row_q;
  assign mem_ras_n  = !in_ras;
  assign mem_cas_n  = !in_cas;
  assign mem_we_n   = !(op_we && in_col);
  assign mem_oe_n   = !(in_cas && !op_we);
  assign mem_dq_oe  = op_we && in_col;
  assign mem_dq_out = wd_q;

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_cnt <= CW'(T_RP);
    else if (!mem_ras_n)              hi_cnt <= '0;
    else if (hi_cnt != {CW{1'b1}})    hi_cnt <= hi_cnt + 1'b1;
  end

  // R6
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> hi_cnt >= CW'(T_RP));

  // R2
  row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> $stable(mem_addr));

  // R3
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cas_n) && !mem_we_n) |-> !$past(mem_we_n));

  // R5
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5
  oe_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);

endmodule

// File: tb/dram_seq_ctrl_test.sv
module dram_seq_ctrl_test;
  localparam int CLK_P = 10;
  localparam int T_RSU = 1, T_RAH = 2, T_CSU = 1, T_CAC = 3, T_RP = 3;
  localparam int HLAT = T_RSU + T_RAH + T_CSU + T_CAC + T_RP + 2;
  localparam int RLAT = T_RSU + T_RAH + T_RP + 2;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0, ref_req = 0;
  logic [17:0] host_addr = '0;
  logic [3:0]  host_wdata = '0, host_rdata, mem_dq_out, mem_dq_in;
  logic [8:0]  ref_row = '0, mem_addr;
  logic host_done, ref_ack, mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int n_chk = 0, n_bad = 0, cyc = 0;

  dram_seq_ctrl #(.T_RSU(T_RSU), .T_RAH(T_RAH), .T_CSU(T_CSU), .T_CAC(T_CAC), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
    .ref_req(ref_req), .ref_row(ref_row), .ref_ack(ref_ack),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [3:0] store [int];
  logic [8:0] row_l = '0, col_l = '0;
  logic [3:0] dq_model = '0;
  int ras_hi = 100, cas_lo = 0, cas_falls = 0, ras_falls = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1, p_dqoe = 0;

  function automatic logic [3:0] peek(input logic [8:0] r, input logic [8:0] c);
    int k = int'({r, c});
    return store.exists(k) ? store[k] : 4'h0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ras && !mem_ras_n) begin
        row_l = mem_addr;
        ras_falls++;
        chk(ras_hi >= T_RP, "R6 precharge", ras_hi, T_RP);
      end
      if (p_cas && !mem_cas_n && !mem_ras_n) begin
        col_l = mem_addr;
        cas_falls++;
        if (!mem_we_n) begin
          chk(!p_we, "R3 we before cas", int'(p_we), 0);
          chk(mem_dq_oe && mem_oe_n, "R3 write drive", int'({mem_dq_oe, mem_oe_n}), 3);
          store[int'({row_l, mem_addr})] = mem_dq_out;
        end
      end
      if (mem_dq_oe && !mem_oe_n) chk(0, "R5 contention", 1, 0);
      if (mem_dq_oe && !p_dqoe && !p_oe) chk(0, "R5 oe late", 0, 1);
    end
    ras_hi = mem_ras_n ? ras_hi + 1 : 0;
    cas_lo = mem_cas_n ? 0 : cas_lo + 1;
    dq_model = (!mem_cas_n && !mem_oe_n && mem_we_n && cas_lo >= T_CAC) ?
               peek(row_l, col_l) : ~peek(row_l, col_l);
    p_ras = mem_ras_n; p_cas = mem_cas_n; p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
  assign mem_dq_in = dq_model;

  task automatic host_op(input logic we, input logic [17:0] a, input logic [3:0] d,
                         output logic [3:0] rd, output int n);
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_wdata = d; n = 0; rd = 'x;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (host_done) begin rd = host_rdata; break; end
    end
    host_req = 0;
    @(negedge clk);
    chk(!host_done, "R9 done one clock", int'(host_done), 0);
  endtask

  task automatic t_reset();
    #1;
    chk({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n} == 4'hF, "R1 strobes in reset",
        int'({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}), 15);
    chk({mem_dq_oe, host_done, ref_ack} == 3'b0, "R1 flags in reset",
        int'({mem_dq_oe, host_done, ref_ack}), 0);
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe} == 5'b11110, "R1 after reset",
        int'({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe}), 30);
  endtask

  task automatic t_write_read(input logic [17:0] a, input logic [3:0] d);
    logic [3:0] rd; int n;
    host_op(1, a, d, rd, n);
    chk(n == HLAT, "R9 write latency", n, HLAT);
    chk(row_l == a[17:9], "R2 write row", int'(row_l), int'(a[17:9]));
    chk(col_l == a[8:0], "R2 write col", int'(col_l), int'(a[8:0]));
    chk(peek(a[17:9], a[8:0]) == d, "R3 stored data", int'(peek(a[17:9], a[8:0])), int'(d));
    host_op(0, a, 4'h0, rd, n);
    chk(n == HLAT, "R9 read latency", n, HLAT);
    chk(rd == d, "R4 R10 read data", int'(rd), int'(d));
  endtask

  task automatic t_refresh(input logic [8:0] r);
    int n = 0, cf = cas_falls;
    bit pulse_ok;
    @(negedge clk); ref_req = 1; ref_row = r;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      chk(mem_cas_n && mem_we_n && mem_oe_n, "R7 refresh strobes", int'({mem_cas_n, mem_we_n, mem_oe_n}), 7);
      if (ref_ack) break;
    end
    ref_req = 0;
    chk(n == RLAT, "R7 refresh latency", n, RLAT);
    chk(row_l == r, "R7 refresh row", int'(row_l), int'(r));
    chk(cas_falls == cf, "R7 no column strobe", cas_falls - cf, 0);
    @(negedge clk);
    pulse_ok = !ref_ack;
    chk(pulse_ok, "R7 ack one clock", int'(ref_ack), 0);
  endtask

  task automatic t_collide(input logic [17:0] a, input logic [8:0] r);
    int n = 0, ta = 0, td = 0;
    logic [3:0] rd = '0;
    @(negedge clk);
    ref_req = 1; ref_row = r; host_req = 1; host_we = 0; host_addr = a;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ref_ack) begin ta = n; ref_req = 0; end
      if (host_done) begin td = n; rd = host_rdata; host_req = 0; end
      if (ta != 0 && td != 0) break;
    end
    chk(ta == RLAT, "R8 refresh first", ta, RLAT);
    chk(td == RLAT + HLAT, "R8 host after refresh", td, RLAT + HLAT);
    chk(rd == peek(a[17:9], a[8:0]), "R8 R10 read after refresh", int'(rd), int'(peek(a[17:9], a[8:0])));
    @(negedge clk);
  endtask

  task automatic t_no_interrupt(input logic [17:0] a, input logic [3:0] d, input logic [8:0] r);
    int n = 0, ta = 0, td = 0;
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 3) begin ref_req = 1; ref_row = r; end
      if (ref_ack) begin ta = n; ref_req = 0; end
      if (host_done) begin td = n; host_req = 0; end
      if (ta != 0 && td != 0) break;
    end
    chk(td == HLAT, "R8 host not interrupted", td, HLAT);
    chk(ta == HLAT + RLAT, "R8 refresh follows", ta, HLAT + RLAT);
    chk(row_l == r, "R8 refresh row", int'(row_l), int'(r));
    chk(peek(a[17:9], a[8:0]) == d, "R3 write kept", int'(peek(a[17:9], a[8:0])), int'(d));
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_write_read(18'h00000, 4'h5);
    t_write_read(18'h3FFFF, 4'hA);
    t_write_read(18'h2A955, 4'hC);
    t_write_read(18'h155AA, 4'h3);
    t_refresh(9'h1FF);
    t_refresh(9'h000);
    t_collide(18'h3FFFF, 9'h0AB);
    t_no_interrupt(18'h12345, 4'h9, 9'h155);
    chk(ras_falls > 10, "R6 strobes seen", ras_falls, 11);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule